// File: doc/BRIEF.md
# Tri-State Phase Detector with Lock Detection

This block compares two divided clock strobes, one from the reference divider and one from the main feedback divider, and drives the up and down enables of an external charge pump. Whichever strobe arrives first turns on its own enable. The enable stays on until the other strobe arrives. Both enables are then cleared together after one cycle in which both are high. When neither enable is on, the pump output floats. This gives the three classic output states: source, sink and high-impedance.

The block also measures how long each comparison lasts, in system-clock cycles. It raises a lock flag once seven comparisons in a row have fallen inside a programmable window. The block passes a 2-bit pump current code to the analog side. That code and a pump disable come in from the register block together with a load strobe. Both are held pending and take effect only at a moment when neither enable is active, so a setting change never cuts a pump pulse short or stretches it.

Top module: `pfd_lock_core`

## Requirements
- R1: After reset, `up`, `dn` and `locked` are low and `cur_code` is 00. The pump is disabled until the first configuration load has been applied.
- R2: If `ref_pulse` strobes first, `up` goes high in the cycle after the strobe and `dn` stays low until `div_pulse` strobes. The mirror case holds for `div_pulse` first, with `dn` high.
- R3: When both enables are high, they stay high for exactly one cycle and then both clear. Strobes arriving in the same cycle give a single cycle with both enables high.
- R4: `cur_code` bit 0 is the low step and bit 1 is the high step. The pump current is 50 µA × (1 + `cur_code`): code 00 gives 50 µA, 01 gives 100 µA, 10 gives 150 µA and 11 gives 200 µA.
- R5: While the applied disable is set, `up`, `dn` and `locked` are all low, and the lock run count restarts from zero.
- R6: Asserting `cfg_load` captures `cur_sel` and `pump_off`. The captured values are applied at the first clock edge after the capture at which neither internal enable is active. `cur_code` never changes in a cycle that follows an active enable.
- R7: A comparison's width is the number of cycles in which exactly one enable is high. After seven consecutive comparisons with a width of at most WIN_CYC (default 12 cycles, which is 240 ns at 50 MHz), `locked` is high in the cycle after the seventh comparison's overlap cycle.
- R8: A comparison with a width greater than WIN_CYC clears the run count and drops `locked` in the same cycle in which a good comparison would have updated it.
- R9: Changes on `cur_sel` or `pump_off` without `cfg_load` have no effect on `cur_code` or on the pump outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle strobe from the reference divider |
| div_pulse | input | 1 | One-cycle strobe from the main divider |
| cur_sel | input | 2 | Requested current code (bit 0 low step, bit 1 high step) |
| pump_off | input | 1 | Requested pump disable |
| cfg_load | input | 1 | Strobe marking the end of a register transfer |
| up | output | 1 | Source-current enable |
| dn | output | 1 | Sink-current enable |
| cur_code | output | 2 | Applied current code |
| locked | output | 1 | Lock indication |

## Verification
The bench probes the window edge with widths of exactly WIN_CYC and WIN_CYC+1. A design with an off-by-one comparison would lock on, or refuse, the boundary width. The bench counts to seven good comparisons and then inserts a single wide one. This catches a lock that arrives one comparison early or late, and a run count that is decremented instead of cleared. A load issued in the middle of a pulse must not change `cur_code` until after the overlap cycle. A design that applied it at once would show the new code while `up` is high. Same-cycle strobes, the disabled pump and unloaded input changes are also covered. A bad design would leave an enable stuck high, keep pumping while disabled, or follow `cur_sel` without a load.

// File: rtl/pfd_lock_core.sv
module pfd_lock_core #(
  parameter int WIN_CYC  = 12,
  parameter int LOCK_RUN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       div_pulse,
  input  logic [1:0] cur_sel,
  input  logic       pump_off,
  input  logic       cfg_load,
  output logic       up,
  output logic       dn,
  output logic [1:0] cur_code,
  output logic       locked
);
  localparam int EW = $clog2(WIN_CYC + 2);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [EW-1:0] WIN_L   = EW'(WIN_CYC);
  localparam logic [EW-1:0] ERR_SAT = EW'(WIN_CYC + 1);
  localparam logic [RW-1:0] RUN_L   = RW'(LOCK_RUN);
  localparam logic [RW-1:0] RUN_M1  = RW'(LOCK_RUN - 1);

  logic          up_q, dn_q, off_q, pend_q, pend_off, lock_q;
  logic [1:0]    cur_q, pend_cur;
  logic [EW-1:0] err_q;
  logic [RW-1:0] run_q;

  wire cmp_end = up_q & dn_q;
  wire idle    = ~up_q & ~dn_q;
  wire good    = err_q <= WIN_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      err_q <= '0;
    end else begin
      up_q <= (up_q | ref_pulse) & ~cmp_end;
      dn_q <= (dn_q | div_pulse) & ~cmp_end;
      if (cmp_end)
        err_q <= '0;
      else if ((up_q ^ dn_q) && err_q != ERR_SAT)
        err_q <= err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_cur <= 2'b00;
      pend_off <= 1'b1;
      cur_q    <= 2'b00;
      off_q    <= 1'b1;
    end else if (cfg_load) begin
      pend_q   <= 1'b1;
      pend_cur <= cur_sel;
      pend_off <= pump_off;
    end else if (pend_q && idle) begin
      pend_q <= 1'b0;
      cur_q  <= pend_cur;
      off_q  <= pend_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (off_q) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (cmp_end) begin
      if (good) begin
        if (run_q != RUN_L) run_q <= run_q + 1'b1;
        lock_q <= (run_q >= RUN_M1);
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign up       = up_q & ~off_q;
  assign dn       = dn_q & ~off_q;
  assign cur_code = cur_q;
  assign locked   = lock_q & ~off_q;
endmodule

// File: rtl/pfd_lock_core_chk.sv
module pfd_lock_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       up_q,
  input logic       dn_q,
  input logic       off_q,
  input logic       up,
  input logic       dn,
  input logic [1:0] cur_code,
  input logic       locked
);
  AST_OVERLAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q)); // R3
  AST_CODE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_code) |-> $past(!up_q && !dn_q)); // R6
  AST_LOCK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(up_q && dn_q)); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> (!up && !dn && !locked)); // R5
  AST_UP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn) |-> $past(up_q || !dn_q)); // R2
endmodule

bind pfd_lock_core pfd_lock_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up_q(up_q), .dn_q(dn_q), .off_q(off_q),
  .up(up), .dn(dn), .cur_code(cur_code), .locked(locked)
);

// File: tb/pfd_lock_core_test.sv
module pfd_lock_core_test;
  localparam int WIN = 12;
  logic clk = 0, rst_n = 0;
  logic ref_pulse = 0, div_pulse = 0, pump_off = 0, cfg_load = 0;
  logic [1:0] cur_sel = 0;
  logic up, dn, locked;
  logic [1:0] cur_code;
  int checks = 0, errors = 0;
  int m_run = 0;
  bit m_off = 1;
  logic [1:0] m_code = 0;

  pfd_lock_core #(.WIN_CYC(WIN), .LOCK_RUN(7)) uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
    .cur_sel(cur_sel), .pump_off(pump_off), .cfg_load(cfg_load),
    .up(up), .dn(dn), .cur_code(cur_code), .locked(locked));

  always #10 clk = ~clk;

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_lock(int run, bit off);
    return !off && run >= 7;
  endfunction

  task automatic model_cmp(int d);
    if (m_off) m_run = 0;
    else if (d <= WIN) m_run = (m_run < 7) ? m_run + 1 : 7;
    else m_run = 0;
  endtask

  task automatic cfg(logic [1:0] sel, bit off);
    @(negedge clk); cur_sel = sel; pump_off = off; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    @(negedge clk);
    m_code = sel; m_off = off;
    if (off) m_run = 0;
    check("R4/R6 code", {2'b0, cur_code}, {2'b0, sel});
  endtask

  task automatic run_cmp(int d, bit ref_first, string req);
    bit e = !m_off;
    @(negedge clk);
    if (d == 0) begin ref_pulse = 1; div_pulse = 1; end
    else if (ref_first) ref_pulse = 1; else div_pulse = 1;
    @(negedge clk); ref_pulse = 0; div_pulse = 0;
    if (d > 0) begin
      check({req, " R2 lead"}, {2'b0, up, dn}, {2'b0, e & ref_first, e & !ref_first});
      repeat (d - 1) @(negedge clk);
      if (ref_first) div_pulse = 1; else ref_pulse = 1;
      @(negedge clk); ref_pulse = 0; div_pulse = 0;
    end
    check({req, " R3 overlap"}, {2'b0, up, dn}, {2'b0, e, e});
    @(negedge clk);
    model_cmp(d);
    check({req, " R3 clear"}, {2'b0, up, dn}, 4'b0);
    check({req, " R7/R8 lock"}, {3'b0, locked}, {3'b0, exp_lock(m_run, m_off)});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outs", {1'b0, up, dn, locked}, 4'b0);
    check("R1 reset code", {2'b0, cur_code}, 4'b0);
    run_cmp(3, 1, "R1 pump off at reset");
    cfg(2'b00, 0);
    run_cmp(4, 1, "R2 ref first");
    run_cmp(5, 0, "R2 div first");
    run_cmp(0, 1, "R3 simultaneous");
    // R9: input change without load
    @(negedge clk); cur_sel = 2'b11; pump_off = 1;
    repeat (3) @(negedge clk);
    check("R9 no load", {2'b0, cur_code}, {2'b0, m_code});
    run_cmp(2, 1, "R9 pump still on");
    cfg(2'b01, 0); cfg(2'b10, 0); cfg(2'b11, 0);
    // R7 lock run, boundary width WIN
    for (int i = 0; i < 7; i++) run_cmp((i == 3) ? WIN : 2, i[0], "R7 run");
    check("R7 locked after seven", {3'b0, locked}, 4'b1);
    run_cmp(WIN + 1, 1, "R8 wide");
    check("R8 dropped", {3'b0, locked}, 4'b0);
    for (int i = 0; i < 6; i++) run_cmp(1, 1, "R7 six");
    check("R7 not yet", {3'b0, locked}, 4'b0);
    run_cmp(1, 0, "R7 seventh");
    check("R7 relock", {3'b0, locked}, 4'b1);
    // R6 deferral during active pulse
    @(negedge clk); ref_pulse = 1;
    @(negedge clk); ref_pulse = 0; cur_sel = 2'b01; pump_off = 0; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    repeat (3) @(negedge clk);
    check("R6 held while up", {1'b0, up, cur_code}, {1'b0, 1'b1, m_code});
    div_pulse = 1;
    @(negedge clk); div_pulse = 0;
    @(negedge clk);
    model_cmp(5);
    check("R6 held at clear", {2'b0, cur_code}, {2'b0, m_code});
    check("R7 lock kept", {3'b0, locked}, {3'b0, exp_lock(m_run, m_off)});
    @(negedge clk);
    m_code = 2'b01;
    check("R6 applied", {2'b0, cur_code}, {2'b0, m_code});
    // R5 disabled pump
    cfg(2'b10, 1);
    check("R5 lock low", {3'b0, locked}, 4'b0);
    run_cmp(3, 1, "R5 off");
    run_cmp(3, 0, "R5 off");
    cfg(2'b00, 0);
    // random
    for (int i = 0; i < 80; i++) begin
      int d = $urandom_range(0, WIN + 4);
      if ($urandom_range(0, 19) == 0) cfg(2'($urandom_range(0, 3)), 0);
      run_cmp(d, 1'($urandom_range(0, 1)), "R7 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule